// File: doc/BRIEF.md
# Serial EEPROM Emulation Sequencer

This controller sits behind a clock-stretching I2C target and makes it act like a read-only serial EEPROM backed by a small memory. The target raises a full flag when the bus controller has written a byte into the target's shift register. It raises an empty flag when the controller has clocked out the byte that was loaded for it. While either flag is up, the target holds the clock low. The sequencer answers each flag event in a fixed order. It updates its own word pointer, which is separate from the bus target address. It fetches the memory byte at that pointer, writes that byte into the shift register, and then pulses a READY status write, which lets the target release the bus.

There are two kinds of access. A random read is a write transfer that carries the word address, followed by one or more read transfers. A sequential read is made of read transfers only, and each one advances the pointer. The word address is one byte long or two bytes long, as chosen by `mode_2b`. In two-byte mode the high byte comes first, and a STOP on the bus restarts that byte count.

The state machine has five states:
- `ST_IDLE` waits for a flag. It moves to `ST_FETCH` on a full flag that completes an address, and on an empty flag. It moves straight to `ST_RELEASE` on a full flag that carries a high address byte.
- `ST_FETCH` presents the pointer to the memory and moves to `ST_LOAD`.
- `ST_LOAD` writes the memory data into the shift register and moves to `ST_RELEASE`.
- `ST_RELEASE` pulses READY and moves to `ST_WAIT_CLR`.
- `ST_WAIT_CLR` waits until both flags are low and then returns to `ST_IDLE`.

Top module: `eeprom_emu_seq`

## Requirements
- R1: After reset, `sr_we` and `ready_stb` are low and `mem_addr` (the pointer) is 0.
- R2: With `mode_2b`=0, a full flag sets the pointer to the received byte, zero-extended and taken modulo DEPTH. The byte stored at that address is then written to the shift register, and READY follows.
- R3: With `mode_2b`=1, the first received byte is the high byte, and the sequencer answers it with READY only, one cycle after the flag is seen, with no shift-register write. The second byte is the low byte. The pointer becomes ({high,low} mod DEPTH), and that byte's data is then loaded, followed by READY.
- R4: A `stop_seen` pulse discards a pending high byte, so the next written byte is treated as a high byte again.
- R5: An empty flag (with full low) advances the pointer by one, wrapping from DEPTH-1 to 0. The byte at the new address is loaded, and READY follows.
- R6: Memory reads take one cycle. Every shift-register write comes in the cycle directly before READY, and READY comes three cycles after the sampled flag on a loading path. `sr_we` and `ready_stb` are never high together.
- R7: Each flag event produces exactly one READY pulse and at most one write. A flag that stays high after READY causes no further action until both flags have dropped.
- R8: When full and empty are seen together, the full flag is serviced and the pointer does not advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_2b | input | 1 | 1: two-byte word address, 0: one-byte |
| stop_seen | input | 1 | One-cycle pulse on a bus STOP |
| sr_full | input | 1 | Target flag: a written byte is waiting |
| sr_empty | input | 1 | Target flag: the loaded byte has been read out |
| sr_rdata | input | DATA_W | Byte received by the target |
| sr_wdata | output | DATA_W | Byte to load into the target shift register |
| sr_we | output | 1 | Shift-register write strobe |
| ready_stb | output | 1 | READY status-write strobe, releases the bus |
| mem_addr | output | clog2(DEPTH) | Memory read address (the word pointer) |
| mem_rdata | input | DATA_W | Memory data, valid one cycle after the address |

## Verification
The hardest case to reach is a STOP that arrives between the high and low address bytes. From the ports it looks like any other write, and only a later pointer value shows that it happened. The bench sends a high byte, pulses STOP, and then sends two more bytes. The resulting address (0x030 rather than 0x100) separates a cleared byte count from a stale one. The end of memory is reached by writing address 0x1FE and then reading past the wrap. One-byte addresses are swept over every value, and two-byte addresses are sampled with high bytes beyond the memory size.

// File: rtl/eeprom_seq_pkg.sv
package eeprom_seq_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_LOAD,
        ST_RELEASE,
        ST_WAIT_CLR
    } seq_state_e;
endpackage

// File: rtl/eeprom_addr_ptr.sv
module eeprom_addr_ptr #(
    parameter int DEPTH  = 512,
    parameter int DATA_W = 8,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_2b,
    input  logic              stop_seen,
    input  logic [DATA_W-1:0] rbyte,
    input  logic              cap_hi,
    input  logic              set_ptr,
    input  logic              inc_ptr,
    output logic              hi_pending,
    output logic [AW-1:0]     ptr
);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic              have_hi;
    logic [DATA_W-1:0] hi_byte;
    logic [AW-1:0]     set_val;

    assign hi_pending = mode_2b && !have_hi;

    always_comb begin
        if (mode_2b) set_val = AW'({hi_byte, rbyte} % DEPTH);
        else         set_val = AW'({{DATA_W{1'b0}}, rbyte} % DEPTH);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            have_hi <= 1'b0;
            hi_byte <= '0;
            ptr     <= '0;
        end else begin
            if (stop_seen) begin
                have_hi <= 1'b0;
            end else if (cap_hi) begin
                have_hi <= 1'b1;
                hi_byte <= rbyte;
            end else if (set_ptr) begin
                have_hi <= 1'b0;
            end
            if (set_ptr)      ptr <= set_val;
            else if (inc_ptr) ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
        end
    end

    assert_ptr_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_ptr && !set_ptr && ptr == LAST) |=> ptr == '0);
    assert_ptr_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_ptr && !set_ptr && ptr != LAST) |=> ptr == $past(ptr) + 1'b1);
    assert_stop_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        stop_seen |=> !have_hi);
    assert_ptr_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_ptr && !inc_ptr) |=> $stable(ptr));
endmodule

// File: rtl/eeprom_seq_fsm.sv
module eeprom_seq_fsm
    import eeprom_seq_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sr_full,
    input  logic              sr_empty,
    input  logic              hi_pending,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              cap_hi,
    output logic              set_ptr,
    output logic              inc_ptr,
    output logic [DATA_W-1:0] sr_wdata,
    output logic              sr_we,
    output logic              ready_stb
);
    seq_state_e state, state_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (sr_full)       state_nx = hi_pending ? ST_RELEASE : ST_FETCH;
                else if (sr_empty) state_nx = ST_FETCH;
            end
            ST_FETCH:    state_nx = ST_LOAD;
            ST_LOAD:     state_nx = ST_RELEASE;
            ST_RELEASE:  state_nx = ST_WAIT_CLR;
            ST_WAIT_CLR: if (!sr_full && !sr_empty) state_nx = ST_IDLE;
            default:     state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        cap_hi    = 1'b0;
        set_ptr   = 1'b0;
        inc_ptr   = 1'b0;
        sr_we     = 1'b0;
        ready_stb = 1'b0;
        sr_wdata  = mem_rdata;
        unique case (state)
            ST_IDLE: begin
                cap_hi  = sr_full && hi_pending;
                set_ptr = sr_full && !hi_pending;
                inc_ptr = !sr_full && sr_empty;
            end
            ST_LOAD:    sr_we     = 1'b1;
            ST_RELEASE: ready_stb = 1'b1;
            default: ;
        endcase
    end

    assert_load_then_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sr_we |=> ready_stb);
    assert_strobes_apart_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(sr_we && ready_stb));
    assert_single_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ready_stb |=> (!ready_stb && !sr_we));
    assert_hi_no_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cap_hi |=> (ready_stb && !$past(sr_we)));
    assert_full_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && sr_full) |-> (!inc_ptr && (cap_hi || set_ptr)));
endmodule

// File: rtl/eeprom_emu_seq.sv
module eeprom_emu_seq #(
    parameter int DEPTH  = 512,
    parameter int DATA_W = 8,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_2b,
    input  logic              stop_seen,
    input  logic              sr_full,
    input  logic              sr_empty,
    input  logic [DATA_W-1:0] sr_rdata,
    output logic [DATA_W-1:0] sr_wdata,
    output logic              sr_we,
    output logic              ready_stb,
    output logic [AW-1:0]     mem_addr,
    input  logic [DATA_W-1:0] mem_rdata
);
    logic cap_hi, set_ptr, inc_ptr, hi_pending;

    eeprom_addr_ptr #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_ptr (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_2b    (mode_2b),
        .stop_seen  (stop_seen),
        .rbyte      (sr_rdata),
        .cap_hi     (cap_hi),
        .set_ptr    (set_ptr),
        .inc_ptr    (inc_ptr),
        .hi_pending (hi_pending),
        .ptr        (mem_addr)
    );

    eeprom_seq_fsm #(.DATA_W(DATA_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .sr_full    (sr_full),
        .sr_empty   (sr_empty),
        .hi_pending (hi_pending),
        .mem_rdata  (mem_rdata),
        .cap_hi     (cap_hi),
        .set_ptr    (set_ptr),
        .inc_ptr    (inc_ptr),
        .sr_wdata   (sr_wdata),
        .sr_we      (sr_we),
        .ready_stb  (ready_stb)
    );

    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (!sr_we && !ready_stb && mem_addr == '0));
endmodule

// File: tb/eeprom_emu_seq_tb.sv
module eeprom_emu_seq_tb;
    localparam int DEPTH = 512;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_2b = 1'b0;
    logic       stop_seen = 1'b0;
    logic       sr_full = 1'b0;
    logic       sr_empty = 1'b0;
    logic [7:0] sr_rdata = 8'h00;
    logic [7:0] sr_wdata;
    logic       sr_we;
    logic       ready_stb;
    logic [8:0] mem_addr;
    logic [7:0] mem_rdata = 8'h00;

    int nchk = 0;
    int nfail = 0;

    always #2 clk = ~clk;

    function automatic logic [7:0] fmem(input int a);
        return 8'((a * 37) ^ (a >> 3) ^ 8'h5A);
    endfunction

    always @(posedge clk) mem_rdata <= fmem(int'(mem_addr));

    eeprom_emu_seq #(.DEPTH(DEPTH), .DATA_W(8)) u_dut (
        .clk(clk), .rst_n(rst_n), .mode_2b(mode_2b), .stop_seen(stop_seen),
        .sr_full(sr_full), .sr_empty(sr_empty), .sr_rdata(sr_rdata),
        .sr_wdata(sr_wdata), .sr_we(sr_we), .ready_stb(ready_stb),
        .mem_addr(mem_addr), .mem_rdata(mem_rdata)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // One flag event: raise flags, wait for READY, check load and timing.
    task automatic xact(input bit f, input bit e, input logic [7:0] b,
                        input bit exp_load, input int exp_addr,
                        input string req, input int hold);
        int cyc = 0;
        int nwe = 0;
        int extra = 0;
        bit prev_we = 1'b0;
        logic [7:0] prev_d = 8'h00;
        @(negedge clk);
        sr_rdata = b;
        sr_full  = f;
        sr_empty = e;
        while (1) begin
            @(negedge clk);
            cyc++;
            if (ready_stb || cyc > 20) break;
            prev_we = sr_we;
            prev_d  = sr_wdata;
            if (sr_we) nwe++;
        end
        check(ready_stb, req, "ready seen", int'(ready_stb), 1);
        if (exp_load) begin
            check(cyc == 3, "R6", "cycles to ready", cyc, 3);
            check(prev_we && nwe == 1, "R6", "write before ready", nwe, 1);
            check(prev_d == fmem(exp_addr), req, "loaded data",
                  int'(prev_d), int'(fmem(exp_addr)));
            check(mem_addr == 9'(exp_addr), req, "pointer",
                  int'(mem_addr), exp_addr);
        end else begin
            check(cyc == 1 && nwe == 0, "R3", "high byte ready only", cyc, 1);
        end
        for (int i = 0; i < hold; i++) begin
            @(negedge clk);
            if (ready_stb || sr_we) extra++;
        end
        sr_full  = 1'b0;
        sr_empty = 1'b0;
        for (int i = 0; i < 2; i++) begin
            @(negedge clk);
            if (ready_stb || sr_we) extra++;
        end
        if (hold > 0) check(extra == 0, "R7", "extra strobes", extra, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(!sr_we && !ready_stb, "R1", "strobes in reset",
              int'({sr_we, ready_stb}), 0);
        check(mem_addr == 9'd0, "R1", "pointer in reset", int'(mem_addr), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!sr_we && !ready_stb && mem_addr == 9'd0, "R1", "idle after reset",
              int'(mem_addr), 0);

        // R2 and R5: all one-byte addresses, each followed by a sequential read
        mode_2b = 1'b0;
        for (int a = 0; a < 256; a++) begin
            xact(1'b1, 1'b0, 8'(a), 1'b1, a, "R2", 0);
            xact(1'b0, 1'b1, 8'h00, 1'b1, (a + 1) % DEPTH, "R5", 0);
        end

        // R5: wrap at the top of memory
        mode_2b = 1'b1;
        xact(1'b1, 1'b0, 8'h01, 1'b0, 0, "R3", 0);
        xact(1'b1, 1'b0, 8'hFE, 1'b1, 16'h1FE, "R3", 0);
        xact(1'b0, 1'b1, 8'h00, 1'b1, 16'h1FF, "R5", 0);
        xact(1'b0, 1'b1, 8'h00, 1'b1, 0, "R5", 0);
        xact(1'b0, 1'b1, 8'h00, 1'b1, 1, "R5", 0);

        // R3: two-byte sweep, high bytes beyond memory are reduced modulo DEPTH
        for (int hi = 0; hi < 4; hi++) begin
            for (int lo = 0; lo < 256; lo += 51) begin
                xact(1'b1, 1'b0, 8'(hi), 1'b0, 0, "R3", 0);
                xact(1'b1, 1'b0, 8'(lo), 1'b1, ((hi << 8) | lo) % DEPTH, "R3", 0);
            end
        end

        // R4: STOP between address bytes restarts with the high byte
        xact(1'b1, 1'b0, 8'h01, 1'b0, 0, "R4", 0);
        @(negedge clk);
        stop_seen = 1'b1;
        @(negedge clk);
        stop_seen = 1'b0;
        xact(1'b1, 1'b0, 8'h00, 1'b0, 0, "R4", 0);
        xact(1'b1, 1'b0, 8'h30, 1'b1, 16'h030, "R4", 0);

        // R7: flag held high after READY
        mode_2b = 1'b0;
        xact(1'b1, 1'b0, 8'h10, 1'b1, 16'h010, "R7", 5);
        xact(1'b0, 1'b1, 8'h00, 1'b1, 16'h011, "R7", 4);

        // R8: both flags together, full wins
        xact(1'b1, 1'b1, 8'h40, 1'b1, 16'h040, "R8", 0);

        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end
endmodule